// File: doc/BRIEF.md
# Pulse Width Capture Timer

An 8-bit up-counting timer/event counter that can measure the width of a single pulse on an external pin. Software loads a preload value and arms the block. The counter then starts from the preload value and advances. In timer mode it advances on prescaled internal clock ticks. In event mode it advances on edges of the pin. In capture mode it advances on prescaled ticks, but only for as long as the pin is held at its active level.

In capture mode the block waits for a leading edge, counts while the pulse lasts, and disarms itself on the trailing edge. The count then stays frozen so software can read it. Each arm gives exactly one measurement. When the counter passes its full value, it reloads the preload value, keeps counting, and can raise a one-cycle interrupt request.

Top module: `pwcap_timer`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), count_out is 0, enabled is 0 and irq_out is 0.
- R2: A preload_wr pulse stores preload_data and loads it into the counter, so count_out shows the value one clock after the write.
- R3: In timer mode (mode_sel 00, or 11 which behaves the same), an arm pulse loads the preload value and sets enabled. The counter then rises by one on each prescaled tick, and enabled stays set until software clears it.
- R4: The prescale field psc_sel = N divides the clock by 2^N. Counting is measured from the arm edge (timer mode) or from the registered leading edge (capture mode). After M further clock edges, floor(M / 2^N) ticks have been applied.
- R5: A tick that finds the counter at 255 reloads the preload value instead of incrementing. One clock later it raises irq_out for one cycle.
- R6: While irq_en is 0, overflows never raise irq_out.
- R7: In capture mode (mode_sel 10), the pin is first passed through a two-stage synchronizer. Suppose it is then held at its active level for L clock edges. The final count equals the preload value advanced by floor(L / 2^N) ticks, and enabled clears by itself on the trailing edge.
- R8: Once capture has completed, further pin transitions leave count_out and enabled unchanged until a new preload write or arm.
- R9: With edge_pol 0, the active level is low: the leading edge is falling and the trailing edge is rising. With edge_pol 1, the active level is high and both polarities are reversed.
- R10: Capture reacts to transitions, not to levels. If the block is armed while the pin is already active, it does not count. A trailing transition seen before any leading one does not disarm the block.
- R11: In event mode (mode_sel 01), each leading edge of the pin adds one to the counter while the block is enabled. The prescaler is not used.
- R12: A disarm pulse clears enabled and stops counting. The count is then held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_sel | input | 2 | 00 timer, 01 event, 10 capture, 11 timer |
| psc_sel | input | 3 | Prescale exponent N (divide by 2^N) |
| edge_pol | input | 1 | 0: active low pulse; 1: active high pulse |
| irq_en | input | 1 | Overflow interrupt enable |
| preload_wr | input | 1 | Preload write strobe |
| preload_data | input | 8 | Preload value |
| arm | input | 1 | Set the enable bit and reload the counter |
| disarm | input | 1 | Software clear of the enable bit |
| pin_in | input | 1 | External pin (asynchronous) |
| count_out | output | 8 | Current counter value |
| enabled | output | 1 | Enable bit readback |
| irq_out | output | 1 | One-cycle overflow interrupt request |

## Verification
The hardest situation to reach from the ports is a capture that crosses one or more overflows under a large prescale ratio. In that case the final count depends on the preload value, the pulse length and the tick phase all at once.

The random stimulus draws preload values near 255, pulse lengths up to a few hundred cycles and prescale exponents up to 3. The expected count and the number of interrupts are then replayed tick by tick. Directed runs cover arming while the pin is already active, a stray trailing edge, and edges arriving after completion.

// File: rtl/pwcap_pkg.sv
// Shared types for the pulse width capture timer.
package pwcap_pkg;
    // Operating mode encoding as seen on mode_sel.
    typedef enum logic [1:0] {
        MODE_TIMER     = 2'b00,
        MODE_EVENT     = 2'b01,
        MODE_CAPTURE   = 2'b10,
        MODE_TIMER_ALT = 2'b11
    } pwcap_mode_e;
endpackage

// File: rtl/pwcap_edge_detect.sv
// Synchronizes the external pin through STAGES flops and reports leading
// and trailing transitions for the chosen polarity.
// Assumes STAGES >= 2 and that pin_in may be fully asynchronous.
module pwcap_edge_detect #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_in,
    input  logic pol,
    output logic lead_edge,
    output logic trail_edge
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;
    logic              lvl, rise, fall;

    // Shift the pin through the synchronizer and keep the last settled level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], pin_in};
            prev_q <= sync_q[STAGES-1];
        end
    end

    // Classify the transition by the selected polarity.
    always_comb begin
        lvl        = sync_q[STAGES-1];
        rise       = lvl & ~prev_q;
        fall       = ~lvl & prev_q;
        lead_edge  = pol ? rise : fall;
        trail_edge = pol ? fall : rise;
    end

    // Two leading edges of one polarity cannot come back to back.
    p_edge_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        lead_edge |=> !(lead_edge && $stable(pol)));
endmodule

// File: rtl/pwcap_prescaler.sv
// Free-running prescaler that issues one tick every 2^sel clocks.
// The clr input restarts the phase so that the first tick comes 2^sel clocks later.
module pwcap_prescaler #(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int CNT_W = (1 << SEL_W) - 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] mask;

    // Build a mask with sel low bits set; tick when they are all ones.
    always_comb begin
        for (int i = 0; i < CNT_W; i++) begin
            mask[i] = (i < int'(sel));
        end
        tick = ((cnt_q & mask) == mask);
    end

    // Advance the phase counter, restarting it on clear.
    always_ff @(posedge clk) begin
        if (!rst_n)   cnt_q <= '0;
        else if (clr) cnt_q <= '0;
        else          cnt_q <= cnt_q + 1'b1;
    end

    // With a ratio above one, a tick is never followed directly by another.
    p_tick_spacing_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && sel != '0) |=> (!tick || sel == '0));
endmodule

// File: rtl/pwcap_counter.sv
// Up counter with a load port and automatic reload from load_val on overflow.
// Assumes load_val holds the preload value whenever load is low.
module pwcap_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         inc,
    output logic [W-1:0] count,
    output logic         ovf
);
    localparam logic [W-1:0] FULL = '1;

    // Flag an increment that would pass the full value.
    always_comb ovf = inc && !load && (count == FULL);

    // Load, reload on overflow, or step the count.
    always_ff @(posedge clk) begin
        if (!rst_n)     count <= '0;
        else if (load)  count <= load_val;
        else if (inc)   count <= (count == FULL) ? load_val : count + 1'b1;
    end

    p_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> count == $past(load_val));
    p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !load && count != FULL) |=> count == $past(count) + 1'b1);
endmodule

// File: rtl/pwcap_timer.sv
// Timer/event counter with a single-shot pulse width capture mode.
// Holds the preload register, the enable bit and the capture-in-progress
// flag, and steers the counter from the prescaler or the pin edges.
// Assumes arm and disarm are single-cycle software strobes.
module pwcap_timer #(
    parameter int W           = 8,
    parameter int PSC_W       = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       mode_sel,
    input  logic [PSC_W-1:0] psc_sel,
    input  logic             edge_pol,
    input  logic             irq_en,
    input  logic             preload_wr,
    input  logic [W-1:0]     preload_data,
    input  logic             arm,
    input  logic             disarm,
    input  logic             pin_in,
    output logic [W-1:0]     count_out,
    output logic             enabled,
    output logic             irq_out
);
    import pwcap_pkg::*;

    pwcap_mode_e mode;
    logic        is_cap, is_evt;
    logic [W-1:0] preload_q, load_val;
    logic        enable_q, active_q, irq_q;
    logic        lead, trail, tick, ovf;
    logic        start_cap, load, inc, psc_clr;

    // Decode the mode and the counter control terms.
    always_comb begin
        mode      = pwcap_mode_e'(mode_sel);
        is_cap    = (mode == MODE_CAPTURE);
        is_evt    = (mode == MODE_EVENT);
        start_cap = is_cap && enable_q && !active_q && lead;
        load      = preload_wr || arm;
        load_val  = preload_wr ? preload_data : preload_q;
        psc_clr   = arm || start_cap;
        if (is_cap)      inc = active_q && tick;
        else if (is_evt) inc = enable_q && lead;
        else             inc = enable_q && tick;
    end

    // Preload register written by software.
    always_ff @(posedge clk) begin
        if (!rst_n)          preload_q <= '0;
        else if (preload_wr) preload_q <= preload_data;
    end

    // Enable bit and capture flag, with self-clear on the trailing edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enable_q <= 1'b0;
            active_q <= 1'b0;
        end else if (disarm) begin
            enable_q <= 1'b0;
            active_q <= 1'b0;
        end else if (arm) begin
            enable_q <= 1'b1;
            active_q <= 1'b0;
        end else if (!is_cap) begin
            active_q <= 1'b0;
        end else if (start_cap) begin
            active_q <= 1'b1;
        end else if (active_q && trail) begin
            active_q <= 1'b0;
            enable_q <= 1'b0;
        end
    end

    // Register the gated overflow as the interrupt request.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= ovf && irq_en;
    end

    pwcap_edge_detect #(.STAGES(SYNC_STAGES)) u_edge (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .pol(edge_pol),
        .lead_edge(lead), .trail_edge(trail)
    );

    pwcap_prescaler #(.SEL_W(PSC_W)) u_psc (
        .clk(clk), .rst_n(rst_n), .clr(psc_clr), .sel(psc_sel), .tick(tick)
    );

    pwcap_counter #(.W(W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .load(load), .load_val(load_val),
        .inc(inc), .count(count_out), .ovf(ovf)
    );

    assign enabled = enable_q;
    assign irq_out = irq_q;

    p_self_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (is_cap && active_q && trail && !arm && !disarm) |=> !enabled);
    p_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable_q && !preload_wr && !arm) |=> $stable(count_out));
    p_irq_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |=> !irq_out);
    p_sw_clear_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_cap && enable_q && !disarm) |=> enabled);
    p_active_needs_arm_r10: assert property (@(posedge clk) disable iff (!rst_n)
        active_q |-> enable_q);
    p_disarm_r12: assert property (@(posedge clk) disable iff (!rst_n)
        disarm |=> !enabled);
endmodule

// File: tb/pwcap_timer_test.sv
module pwcap_timer_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode_sel = 2'b00;
    logic [2:0] psc_sel = 3'd0;
    logic       edge_pol = 1'b0;
    logic       irq_en = 1'b0;
    logic       preload_wr = 1'b0;
    logic [7:0] preload_data = 8'd0;
    logic       arm = 1'b0;
    logic       disarm = 1'b0;
    logic       pin_in = 1'b1;
    logic [7:0] count_out;
    logic       enabled;
    logic       irq_out;

    int checks = 0;
    int fails = 0;
    int irq_seen = 0;
    int cyc = 0;

    pwcap_timer uut (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .psc_sel(psc_sel),
        .edge_pol(edge_pol), .irq_en(irq_en), .preload_wr(preload_wr),
        .preload_data(preload_data), .arm(arm), .disarm(disarm),
        .pin_in(pin_in), .count_out(count_out), .enabled(enabled),
        .irq_out(irq_out)
    );

    always #5 clk = ~clk;

    always @(negedge clk) begin
        #1;
        if (irq_out) irq_seen++;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++;
            $display("FAIL watchdog: actual %0d cycles, expected fewer than 150000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Replays ticks on the counter: reload on passing full, counting overflows.
    function automatic void model(input int pre, input int ticks,
                                  output int cnt, output int ovf);
        cnt = pre;
        ovf = 0;
        for (int t = 0; t < ticks; t++) begin
            if (cnt == 255) begin cnt = pre; ovf++; end
            else cnt++;
        end
    endfunction

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_preload(input int v);
        preload_wr = 1'b1;
        preload_data = v[7:0];
        @(negedge clk);
        preload_wr = 1'b0;
        chk("R2 preload load", count_out, v);
    endtask

    task automatic pulse_arm();
        arm = 1'b1;
        @(negedge clk);
        arm = 1'b0;
    endtask

    task automatic timer_run(input int n, input int m, input int pre, input bit ien);
        int cnt, ovf, base;
        mode_sel = 2'b00; psc_sel = n[2:0]; irq_en = ien;
        write_preload(pre);
        idle(2);
        base = irq_seen;
        pulse_arm();
        repeat (m) @(negedge clk);
        model(pre, m >> n, cnt, ovf);
        chk("R3/R4 timer count", count_out, cnt);
        chk("R3 enable holds", enabled, 1);
        disarm = 1'b1;
        @(negedge clk);
        disarm = 1'b0;
        idle(3);
        model(pre, (m + 1) >> n, cnt, ovf);
        chk("R12 held after disarm", count_out, cnt);
        chk("R12 enable cleared", enabled, 0);
        chk("R5/R6 irq pulses", irq_seen - base, ien ? ovf : 0);
    endtask

    task automatic capture_run(input bit pol, input int n, input int len,
                               input int pre, input bit ien);
        int cnt, ovf, base, hold;
        mode_sel = 2'b10; edge_pol = pol; psc_sel = n[2:0]; irq_en = ien;
        pin_in = ~pol;
        write_preload(pre);
        idle(4);
        base = irq_seen;
        pulse_arm();
        idle(2);
        pin_in = pol;
        repeat (len) @(negedge clk);
        pin_in = ~pol;
        idle(5);
        model(pre, len >> n, cnt, ovf);
        chk("R7/R9 capture count", count_out, cnt);
        chk("R7 self clear", enabled, 0);
        chk("R5/R6 capture irq", irq_seen - base, ien ? ovf : 0);
        hold = count_out;
        for (int k = 0; k < 3; k++) begin
            pin_in = pol; idle(3);
            pin_in = ~pol; idle(3);
        end
        chk("R8 frozen count", count_out, hold);
        chk("R8 stays disarmed", enabled, 0);
    endtask

    initial begin
        int cnt, ovf;
        void'($urandom(32'd20240611));
        idle(3);
        chk("R1 count reset", count_out, 0);
        chk("R1 enable reset", enabled, 0);
        chk("R1 irq reset", irq_out, 0);
        rst_n = 1'b1;
        idle(2);

        // Directed corners.
        timer_run(0, 20, 10, 1'b1);
        timer_run(3, 100, 250, 1'b1);
        timer_run(0, 40, 255, 1'b1);
        timer_run(2, 80, 240, 1'b0);
        mode_sel = 2'b11;
        capture_run(1'b0, 0, 17, 3, 1'b1);
        capture_run(1'b1, 2, 33, 250, 1'b1);
        capture_run(1'b0, 3, 300, 200, 1'b0);

        // R10: arm while the pin already sits at the active level.
        mode_sel = 2'b10; edge_pol = 1'b0; psc_sel = 3'd0; irq_en = 1'b0;
        pin_in = 1'b0;
        write_preload(50);
        idle(4);
        pulse_arm();
        idle(10);
        chk("R10 no count at level", count_out, 50);
        pin_in = 1'b1;
        idle(5);
        chk("R10 stray trailing edge ignored", enabled, 1);
        chk("R10 count unchanged", count_out, 50);
        pin_in = 1'b0;
        idle(9);
        pin_in = 1'b1;
        idle(5);
        chk("R10 fresh edge measures", count_out, 59);
        chk("R7 cleared after fresh pulse", enabled, 0);

        // R11: event mode counts leading edges.
        mode_sel = 2'b01; edge_pol = 1'b0; psc_sel = 3'd5; pin_in = 1'b1;
        write_preload(250);
        idle(4);
        pulse_arm();
        for (int p = 0; p < 9; p++) begin
            pin_in = 1'b0; idle(2);
            pin_in = 1'b1; idle(2);
        end
        idle(4);
        model(250, 9, cnt, ovf);
        chk("R11 event count", count_out, cnt);
        chk("R11 enable holds", enabled, 1);
        disarm = 1'b1; @(negedge clk); disarm = 1'b0;
        edge_pol = 1'b1; pin_in = 1'b0; idle(4);
        pulse_arm();
        for (int p = 0; p < 5; p++) begin
            pin_in = 1'b1; idle(2);
            pin_in = 1'b0; idle(2);
        end
        idle(4);
        chk("R9/R11 rising edge count", count_out, 255);
        disarm = 1'b1; @(negedge clk); disarm = 1'b0;

        // Random mix.
        for (int it = 0; it < 30; it++) begin
            int n, len, pre;
            bit ien, pol;
            n = $urandom_range(0, 3);
            len = $urandom_range(1, 300);
            pre = ($urandom_range(0, 1) == 1) ? $urandom_range(200, 255) : $urandom_range(0, 255);
            ien = $urandom_range(0, 1);
            pol = $urandom_range(0, 1);
            if (it % 2 == 0) capture_run(pol, n, len, pre, ien);
            else             timer_run(n, len + 100, pre, ien);
        end

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule